// File: doc/BRIEF.md
# Timer Frame Access Gate

This block stands in front of a group of up to eight timer frames and rules on every register access aimed at them. Each request names a frame, a byte offset inside that frame, a direction (read or write), whether the initiator is secure, and which of two views it comes through. The views are the full view and a reduced alias meant for less privileged software. The gate combines three layers of permission into a single allow/deny verdict:
- a per-frame bit that opens the frame to non-secure initiators;
- a per-frame word of top-level access rights, one right per register group;
- a per-frame permission word that further narrows what the alias view may reach.

A frame whose feature byte does not mark it as present is never reachable.

Requests arrive on a valid/ready channel. Verdicts leave on a second valid/ready channel one cycle after acceptance, together with the feature byte of the addressed frame.
- An accepted, allowed write raises a single-cycle write strobe toward the frames in the same cycle as the acceptance.
- Read data presented by the frames alongside the request passes through only for an allowed read. Otherwise the response carries zero.
- A refused access never raises a bus error.
- While the response is stalled, `req_ready` is low and the pending response is held unchanged.

Top module: `frame_access_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1; its response appears with `rsp_valid` = 1 on the next cycle. `req_ready` is 1 exactly when no response is pending or `rsp_ready` is 1, and a stalled response keeps every field unchanged.
- R3: A frame whose feature byte bit 0 (present) is 0 refuses every access.
- R4: A non-secure request (`req_secure` = 0) to frame k is refused unless bit k of `ns_enable` is 1; secure requests ignore `ns_enable`.
- R5: Offsets decode on bits [5:2] with bits [1:0] ignored. The groups are physical count at 0x00–0x07, virtual count at 0x08–0x0F, frequency at 0x10, alias permission word at 0x14, virtual offset at 0x18–0x1F, physical timer at 0x20–0x2F and virtual timer at 0x30–0x3F. The frame's 6-bit access word (`acc_words` bits [6k+5:6k]) grants them in this way:
  - physical count reads need bit 0;
  - virtual count reads need bit 1;
  - frequency reads need bit 2;
  - virtual offset reads need bit 3;
  - virtual timer reads and writes need bit 4;
  - physical timer reads and writes need bit 5.

  Writes to either count, to the frequency or to the virtual offset are refused.
- R6: Virtual count, virtual offset and virtual timer accesses are refused when feature bit 1 (virtual capable) is 0.
- R7: Alias-view requests (`req_view` = 1) are refused when feature bit 2 (alias present) is 0. Otherwise, on top of R5, they also need bits of the frame's 10-bit permission word (`view_perm` bits [10k+9:10k]):
  - physical count needs bit 0;
  - virtual count needs bit 1;
  - frequency needs bit 0 or bit 1;
  - virtual timer needs bit 8;
  - physical timer needs bit 9.
- R8: The alias view never reaches the virtual offset or the permission word at 0x14. In the full view the permission word is readable and writable once R3 and R4 pass.
- R9: Any offset of 0x40 or above is refused.
- R10: `frm_wr_en` is 1 only in a cycle that accepts an allowed write. The response data equals `frm_rdata` for an allowed read and is zero for a refused read and for any write.
- R11: `rsp_feat` carries the full feature byte (`feat_bytes` bits [8k+7:8k]) of the addressed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ns_enable | input | N_FRAMES | Per-frame non-secure enable |
| acc_words | input | 6*N_FRAMES | Per-frame access-rights words |
| view_perm | input | 10*N_FRAMES | Per-frame alias permission words |
| feat_bytes | input | 8*N_FRAMES | Per-frame feature bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_frame | input | FIDX_W | Frame index |
| req_offset | input | OFS_W | Byte offset in the frame |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure initiator |
| req_view | input | 1 | 1 = alias view, 0 = full view |
| frm_rdata | input | DATA_W | Read data from the addressed frame, valid with the request |
| frm_wr_en | output | 1 | Write strobe to the frames for an allowed write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_allow | output | 1 | 1 = access allowed |
| rsp_rdata | output | DATA_W | Masked read data |
| rsp_feat | output | 8 | Feature byte of the addressed frame |

## Verification
The bench sweeps every frame, every offset group up to just past the decoded range (with non-zero low address bits), both directions, both security states and both views, under several configurations. These include frames marked absent, frames without virtual capability or alias, and sparse rights and permission words.

A design that skipped the present bit or the non-secure bit would allow refused accesses. Letting the alias reach the offset or permission word, or letting a write land on a read-only counter, would raise `frm_wr_en` where the model forbids it. Dropping the "either bit" rule for the alias frequency read would refuse reads that should pass.

A stall scenario shows a response that changed or was overwritten under back-pressure, and an extra write strobe while `req_ready` is low.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  localparam int ACC_W  = 6;
  localparam int PERM_W = 10;
  localparam int FEAT_W = 8;

  // access-word bit positions
  localparam int AB_PCNT = 0;
  localparam int AB_VCNT = 1;
  localparam int AB_FREQ = 2;
  localparam int AB_VOFF = 3;
  localparam int AB_VTMR = 4;
  localparam int AB_PTMR = 5;

  // alias permission bit positions
  localparam int PB_PCNT = 0;
  localparam int PB_VCNT = 1;
  localparam int PB_VTMR = 8;
  localparam int PB_PTMR = 9;

  // feature bit positions
  localparam int FB_PRES = 0;
  localparam int FB_VIRT = 1;
  localparam int FB_ALIAS = 2;

  typedef enum logic [2:0] {
    RC_PCNT, RC_VCNT, RC_FREQ, RC_PERM, RC_VOFF, RC_PTMR, RC_VTMR, RC_NONE
  } reg_cls_e;
endpackage

// File: rtl/tfg_decode.sv
module tfg_decode
  import tfg_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic [OFS_W-1:0] ofs,
  output reg_cls_e         cls
);
  logic hi_range;
  logic unused_low;

  assign hi_range   = |ofs[OFS_W-1:6];
  assign unused_low = ^ofs[1:0];

  always_comb begin
    if (hi_range) begin
      cls = RC_NONE;
    end else begin
      unique case (ofs[5:2])
        4'd0, 4'd1:                 cls = RC_PCNT;
        4'd2, 4'd3:                 cls = RC_VCNT;
        4'd4:                       cls = RC_FREQ;
        4'd5:                       cls = RC_PERM;
        4'd6, 4'd7:                 cls = RC_VOFF;
        4'd8, 4'd9, 4'd10, 4'd11:   cls = RC_PTMR;
        default:                    cls = RC_VTMR;
      endcase
    end
  end
endmodule

// File: rtl/tfg_policy.sv
module tfg_policy
  import tfg_pkg::*;
#(
  parameter int N_FRAMES = 8,
  parameter int FIDX_W   = 3
) (
  input  logic [N_FRAMES-1:0]        ns_enable,
  input  logic [N_FRAMES*ACC_W-1:0]  acc_words,
  input  logic [N_FRAMES*PERM_W-1:0] view_perm,
  input  logic [N_FRAMES*FEAT_W-1:0] feat_bytes,
  input  logic [FIDX_W-1:0]          frame,
  input  reg_cls_e                   cls,
  input  logic                       write,
  input  logic                       secure,
  input  logic                       view,
  output logic                       allow,
  output logic [FEAT_W-1:0]          feat
);
  logic [ACC_W-1:0]  acc_a  [N_FRAMES];
  logic [PERM_W-1:0] perm_a [N_FRAMES];
  logic [FEAT_W-1:0] feat_a [N_FRAMES];

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
    assign acc_a[g]  = acc_words[g*ACC_W +: ACC_W];
    assign perm_a[g] = view_perm[g*PERM_W +: PERM_W];
    assign feat_a[g] = feat_bytes[g*FEAT_W +: FEAT_W];
  end

  logic              in_range;
  logic [ACC_W-1:0]  a;
  logic [PERM_W-1:0] p;
  logic [FEAT_W-1:0] f;
  logic              ns_ok;
  logic              base_ok;
  logic              alias_ok;

  assign in_range = (32'(frame) < N_FRAMES);

  always_comb begin
    a = '0;
    p = '0;
    f = '0;
    ns_ok = 1'b0;
    for (int i = 0; i < N_FRAMES; i++) begin
      if (in_range && 32'(frame) == i) begin
        a = acc_a[i];
        p = perm_a[i];
        f = feat_a[i];
        ns_ok = ns_enable[i];
      end
    end
  end

  always_comb begin
    base_ok  = 1'b0;
    alias_ok = 1'b0;
    unique case (cls)
      RC_PCNT: begin
        base_ok  = !write && a[AB_PCNT];
        alias_ok = p[PB_PCNT];
      end
      RC_VCNT: begin
        base_ok  = !write && a[AB_VCNT] && f[FB_VIRT];
        alias_ok = p[PB_VCNT];
      end
      RC_FREQ: begin
        base_ok  = !write && a[AB_FREQ];
        alias_ok = p[PB_PCNT] || p[PB_VCNT];
      end
      RC_PERM: begin
        base_ok  = 1'b1;
        alias_ok = 1'b0;
      end
      RC_VOFF: begin
        base_ok  = !write && a[AB_VOFF] && f[FB_VIRT];
        alias_ok = 1'b0;
      end
      RC_PTMR: begin
        base_ok  = a[AB_PTMR];
        alias_ok = p[PB_PTMR];
      end
      RC_VTMR: begin
        base_ok  = a[AB_VTMR] && f[FB_VIRT];
        alias_ok = p[PB_VTMR];
      end
      default: begin
        base_ok  = 1'b0;
        alias_ok = 1'b0;
      end
    endcase
  end

  assign allow = in_range && f[FB_PRES] && (secure || ns_ok) && base_ok
               && (!view || (f[FB_ALIAS] && alias_ok));
  assign feat  = f;
endmodule

// File: rtl/tfg_rsp_stage.sv
module tfg_rsp_stage #(
  parameter int DATA_W = 32,
  parameter int FEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic              in_allow,
  input  logic [DATA_W-1:0] in_rdata,
  input  logic [FEAT_W-1:0] in_feat,
  output logic              can_accept,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [FEAT_W-1:0] rsp_feat
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_rdata <= '0;
      rsp_feat  <= '0;
    end else if (can_accept) begin
      rsp_valid <= in_fire;
      if (in_fire) begin
        rsp_allow <= in_allow;
        rsp_rdata <= in_rdata;
        rsp_feat  <= in_feat;
      end
    end
  end
endmodule

// File: rtl/frame_access_gate.sv
module frame_access_gate
  import tfg_pkg::*;
#(
  parameter int N_FRAMES = 8,
  parameter int OFS_W    = 12,
  parameter int DATA_W   = 32,
  localparam int FIDX_W  = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_FRAMES-1:0]        ns_enable,
  input  logic [N_FRAMES*6-1:0]      acc_words,
  input  logic [N_FRAMES*10-1:0]     view_perm,
  input  logic [N_FRAMES*8-1:0]      feat_bytes,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [FIDX_W-1:0]          req_frame,
  input  logic [OFS_W-1:0]           req_offset,
  input  logic                       req_write,
  input  logic                       req_secure,
  input  logic                       req_view,
  input  logic [DATA_W-1:0]          frm_rdata,
  output logic                       frm_wr_en,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_allow,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [7:0]                 rsp_feat
);
  reg_cls_e          cls;
  logic              allow;
  logic [FEAT_W-1:0] feat;
  logic              fire;
  logic [DATA_W-1:0] masked;

  tfg_decode #(.OFS_W(OFS_W)) u_decode (
    .ofs (req_offset),
    .cls (cls)
  );

  tfg_policy #(.N_FRAMES(N_FRAMES), .FIDX_W(FIDX_W)) u_policy (
    .ns_enable  (ns_enable),
    .acc_words  (acc_words),
    .view_perm  (view_perm),
    .feat_bytes (feat_bytes),
    .frame      (req_frame),
    .cls        (cls),
    .write      (req_write),
    .secure     (req_secure),
    .view       (req_view),
    .allow      (allow),
    .feat       (feat)
  );

  assign fire      = req_valid && req_ready;
  assign frm_wr_en = fire && req_write && allow;
  assign masked    = (allow && !req_write) ? frm_rdata : '0;

  tfg_rsp_stage #(.DATA_W(DATA_W), .FEAT_W(FEAT_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (fire),
    .in_allow   (allow),
    .in_rdata   (masked),
    .in_feat    (feat),
    .can_accept (req_ready),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow),
    .rsp_rdata  (rsp_rdata),
    .rsp_feat   (rsp_feat)
  );
endmodule

// File: rtl/tfg_gate_chk.sv
module tfg_gate_chk #(
  parameter int N_FRAMES = 8,
  parameter int OFS_W    = 12,
  parameter int DATA_W   = 32,
  localparam int FIDX_W  = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_FRAMES-1:0]   ns_enable,
  input logic [N_FRAMES*8-1:0] feat_bytes,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [FIDX_W-1:0]     req_frame,
  input logic [OFS_W-1:0]      req_offset,
  input logic                  req_write,
  input logic                  req_secure,
  input logic                  req_view,
  input logic                  frm_wr_en,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic                  rsp_allow,
  input logic [DATA_W-1:0]     rsp_rdata,
  input logic [7:0]            rsp_feat
);
  logic low_range;
  logic in_timer;
  logic alias_hidden;
  assign low_range    = !(|req_offset[OFS_W-1:6]);
  assign in_timer     = low_range && req_offset[5];
  assign alias_hidden = low_range && (req_offset[5:2] inside {4'd5, 4'd6, 4'd7});

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  a_r2_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_allow)
                                && $stable(rsp_rdata) && $stable(rsp_feat));

  a_r10_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_allow |-> rsp_rdata == '0);

  a_r10_strobe_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr_en |-> req_valid && req_ready && req_write);

  a_r4_ns_gate: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr_en && !req_secure |-> ns_enable[req_frame]);

  a_r3_present: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr_en |-> feat_bytes[32'(req_frame)*8]);

  a_r8_alias_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr_en && req_view |-> !alias_hidden);

  a_r5_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr_en |-> in_timer || (!req_view && low_range && req_offset[5:2] == 4'd5));
endmodule

bind frame_access_gate tfg_gate_chk #(
  .N_FRAMES (N_FRAMES),
  .OFS_W    (OFS_W),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/frame_access_gate_tb.sv
module frame_access_gate_tb;
  localparam int N  = 8;
  localparam int OW = 12;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    ns_enable = '0;
  logic [N*6-1:0]  acc_words = '0;
  logic [N*10-1:0] view_perm = '0;
  logic [N*8-1:0]  feat_bytes = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [2:0]      req_frame = '0;
  logic [OW-1:0]   req_offset = '0;
  logic            req_write = 1'b0;
  logic            req_secure = 1'b0;
  logic            req_view = 1'b0;
  logic [DW-1:0]   frm_rdata = '0;
  logic            frm_wr_en;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic            rsp_allow;
  logic [DW-1:0]   rsp_rdata;
  logic [7:0]      rsp_feat;

  always #5ns clk = ~clk;

  frame_access_gate #(.N_FRAMES(N), .OFS_W(OW), .DATA_W(DW)) u_dut (.*);

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  bit [5:0] c_acc  [N];
  bit [9:0] c_perm [N];
  bit [7:0] c_feat [N];
  bit       c_ns   [N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int r);
    for (int f = 0; f < N; f++) begin
      if (r == 0) begin
        c_acc[f]  = 6'h3F;
        c_perm[f] = 10'h3FF;
        c_feat[f] = 8'h07 | 8'(f << 4);
        c_ns[f]   = 1'b1;
      end else begin
        c_acc[f]  = 6'(f*13 + r*29 + 5);
        c_perm[f] = 10'(f*181 + r*97 + 3);
        c_feat[f] = 8'((f*37 + r*11) ^ 8'h5A);
        c_feat[f][0] = ((f + r) % 5) != 0;
        c_ns[f]   = ((f + r) % 3) != 0;
      end
      ns_enable[f]            = c_ns[f];
      acc_words[f*6 +: 6]     = c_acc[f];
      view_perm[f*10 +: 10]   = c_perm[f];
      feat_bytes[f*8 +: 8]    = c_feat[f];
    end
  endtask

  // independent model of the requirements
  function automatic bit exp_allow(input int f, input int ofs, input bit wr, input bit sec, input bit vw);
    int w;
    bit rights;
    bit narrow;
    bit virt_needed;
    w = ofs >> 2;
    if (!c_feat[f][0]) return 0;          // R3
    if (!sec && !c_ns[f]) return 0;       // R4
    if (ofs >= 'h40) return 0;            // R9
    virt_needed = 0;
    narrow = 0;
    if (w < 2)       begin rights = !wr && c_acc[f][0]; narrow = c_perm[f][0]; end
    else if (w < 4)  begin rights = !wr && c_acc[f][1]; narrow = c_perm[f][1]; virt_needed = 1; end
    else if (w == 4) begin rights = !wr && c_acc[f][2]; narrow = c_perm[f][0] | c_perm[f][1]; end
    else if (w == 5) begin rights = 1; narrow = 0; end
    else if (w < 8)  begin rights = !wr && c_acc[f][3]; narrow = 0; virt_needed = 1; end
    else if (w < 12) begin rights = c_acc[f][5]; narrow = c_perm[f][9]; end
    else             begin rights = c_acc[f][4]; narrow = c_perm[f][8]; virt_needed = 1; end
    if (virt_needed && !c_feat[f][1]) return 0;  // R6
    if (!rights) return 0;                       // R5
    if (vw && !(c_feat[f][2] && narrow)) return 0; // R7, R8
    return 1;
  endfunction

  function automatic string tag_for(input int f, input int ofs, input bit sec, input bit vw);
    int w;
    w = ofs >> 2;
    if (!c_feat[f][0]) return "R3";
    if (!sec && !c_ns[f]) return "R4";
    if (ofs >= 'h40) return "R9";
    if (vw && (w == 5 || w == 6 || w == 7)) return "R8";
    if (!c_feat[f][1] && ((w >= 2 && w < 4) || (w >= 6 && w < 8) || w >= 12)) return "R6";
    if (vw) return "R7";
    return "R5";
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a_data;
    bit            ea;
    set_cfg(0);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);

    // exhaustive sweep
    for (int r = 0; r < 5; r++) begin
      set_cfg(r);
      for (int f = 0; f < N; f++) begin
        for (int o = 0; o < 19; o++) begin
          for (int k = 0; k < 8; k++) begin
            int   ofs;
            bit   wr, sec, vw;
            logic [DW-1:0] d;
            string tg;
            ofs = o*4 + (o % 4);
            wr = k[0]; sec = k[1]; vw = k[2];
            d  = {8'hC3, 8'(f), 16'(ofs)} ^ 32'(k << 20);
            req_valid  = 1'b1;
            req_frame  = 3'(f);
            req_offset = OW'(ofs);
            req_write  = wr;
            req_secure = sec;
            req_view   = vw;
            frm_rdata  = d;
            #1;
            ea = exp_allow(f, ofs, wr, sec, vw);
            tg = tag_for(f, ofs, sec, vw);
            chk(frm_wr_en == (ea && wr), {"R10 frm_wr_en ", tg}, 64'(frm_wr_en), 64'(ea && wr));
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 1);
            chk(rsp_allow == ea, {tg, " rsp_allow"}, 64'(rsp_allow), 64'(ea));
            chk(rsp_rdata == ((ea && !wr) ? d : '0), "R10 rsp_rdata",
                64'(rsp_rdata), 64'((ea && !wr) ? d : '0));
            chk(rsp_feat == c_feat[f], "R11 rsp_feat", 64'(rsp_feat), 64'(c_feat[f]));
          end
        end
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 idle rsp_valid", 64'(rsp_valid), 0);
    end

    // back-pressure scenario (R2)
    set_cfg(0);
    rsp_ready  = 1'b0;
    req_valid  = 1'b1;
    req_frame  = 3'd2;
    req_offset = 12'h010;
    req_write  = 1'b0;
    req_secure = 1'b0;
    req_view   = 1'b1;
    a_data     = 32'h1234_5678;
    frm_rdata  = a_data;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2 stalled rsp_valid", 64'(rsp_valid), 1);
    chk(req_ready == 1'b0, "R2 req_ready under stall", 64'(req_ready), 0);
    req_frame  = 3'd5;
    req_offset = 12'h024;
    req_write  = 1'b1;
    req_secure = 1'b1;
    req_view   = 1'b0;
    frm_rdata  = 32'hDEAD_BEEF;
    #1;
    chk(frm_wr_en == 1'b0, "R2 no strobe while stalled", 64'(frm_wr_en), 0);
    @(negedge clk);
    chk(rsp_rdata == a_data, "R2 held rdata", 64'(rsp_rdata), 64'(a_data));
    chk(rsp_feat == c_feat[2], "R2 held feat", 64'(rsp_feat), 64'(c_feat[2]));
    chk(rsp_allow == 1'b1, "R2 held allow", 64'(rsp_allow), 1);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R2 req_ready on drain", 64'(req_ready), 1);
    chk(frm_wr_en == 1'b1, "R10 strobe after drain", 64'(frm_wr_en), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_feat == c_feat[5], "R2 second response feat", 64'(rsp_feat), 64'(c_feat[5]));
    chk(rsp_rdata == '0, "R10 write rdata zero", 64'(rsp_rdata), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 drained", 64'(rsp_valid), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule